// File: doc/BRIEF.md
# Byte-Lane Width Adapter (64-bit master to 8-bit slave)

This block connects a 64-bit Wishbone classic master to a slave whose data path is a single byte, such as a small peripheral register file. The master marks the byte it wants with one of eight lane-select bits. The adapter turns that lane into the three least significant bits of the slave's 12-bit address. On a write it takes the byte from the matching lane of the wide write bus. On a read it places the slave's byte back into the same lane of the wide read bus.

A master cycle that selects more than one lane is never split into several narrow accesses, and neither is a cycle that selects no lane. The adapter rejects such a cycle. It keeps the slave's cycle line low and answers the master itself with a single-cycle acknowledge, an all-ones read word and an error pulse. As a result, each master cycle causes at most one slave access. Accepted cycles add no wait states, because the master acknowledge follows the slave acknowledge combinationally.

Top module: `wbna_adapter`

## Requirements
- R1: While a cycle is accepted, the slave address is the master word address (9 bits) in bits 11..3, with the index of the single active lane-select bit in bits 2..0. Select bit k maps to index k.
- R2: The slave write byte equals bits 8k+7..8k of the master write word, where k is the active lane.
- R3: The slave write-enable and strobe always equal the master write-enable and strobe, whether or not a cycle is accepted.
- R4: A master cycle with two or more select bits set never raises the slave cycle line.
- R5: A master cycle with no select bit set never raises the slave cycle line.
- R6: A rejected strobe gets no acknowledge in its first cycle. In the next cycle it gets exactly one cycle of acknowledge, together with the error output and a read word of all ones. The acknowledge is high for a single cycle only, even if the strobe stays high.
- R7: For an accepted cycle, the read word carries the slave's byte in lane k. All other lanes read as zero.
- R8: For an accepted cycle, the master acknowledge equals the slave acknowledge in the same cycle, and the error output stays low.
- R9: While reset is held and no cycle is active, the acknowledge and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_wadr | input | 9 | Master word address (slave address bits 11..3) |
| m_dat_w | input | 64 | Master write data |
| m_sel | input | 8 | Master byte-lane selects |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_dat_r | output | 64 | Read data to master |
| m_ack | output | 1 | Acknowledge to master |
| m_err | output | 1 | Error to master (rejected cycle) |
| s_adr | output | 12 | Slave byte address |
| s_dat_w | output | 8 | Slave write data |
| s_we | output | 1 | Slave write enable |
| s_stb | output | 1 | Slave strobe |
| s_cyc | output | 1 | Slave cycle, accepted cycles only |
| s_dat_r | input | 8 | Slave read data |
| s_ack | input | 1 | Slave acknowledge |

## Verification
The bench covers every one of the eight single-lane positions. A design with a lane encoder that is wrong by one would put the byte at the wrong address and return it in the wrong lane. The bench also drives multi-lane patterns, including adjacent pairs, the two end lanes together and all eight lanes. It drives zero-select cycles as well. An adapter that used the lowest set bit, or that treated an empty select as lane 0, would leak those cycles to the slave. While the rejected cycles are in progress, the slave acknowledge is held high. A missing gate would then acknowledge the rejected cycle in its first cycle. The bench also holds the strobe high on a rejected cycle to catch a local acknowledge that never drops.

// File: rtl/wbna_pkg.sv
package wbna_pkg;

  // Where the current master cycle is headed.
  typedef enum logic [1:0] {
    ROUTE_IDLE = 2'd0,
    ROUTE_FWD  = 2'd1,
    ROUTE_REJ  = 2'd2
  } route_e;

endpackage

// File: rtl/wbna_lane_decode.sv
module wbna_lane_decode
  import wbna_pkg::*;
#(
  parameter int LANES = 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] sel,
  input  logic             cyc,
  output logic             one_hot,
  output logic [IDX_W-1:0] lane_idx,
  output route_e           route
);

  // Number of asserted select bits.
  function automatic int count_set(input logic [LANES-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

  // Index of the lowest asserted bit; zero when none is set.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [LANES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  int set_count;

  always_comb begin
    set_count = count_set(sel);
    one_hot   = (set_count == 1);
    lane_idx  = lowest_set(sel);
    if (!cyc)         route = ROUTE_IDLE;
    else if (one_hot) route = ROUTE_FWD;
    else              route = ROUTE_REJ;
  end

endmodule

// File: rtl/wbna_wr_mux.sv
module wbna_wr_mux #(
  parameter int M_DW = 64,
  parameter int S_DW = 8,
  localparam int LANES = M_DW / S_DW,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [M_DW-1:0]  wide,
  input  logic [IDX_W-1:0] lane_idx,
  output logic [S_DW-1:0]  narrow
);

  logic [S_DW-1:0] lane_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_arr[g] = wide[g*S_DW +: S_DW];
  end

  assign narrow = lane_arr[lane_idx];

endmodule

// File: rtl/wbna_rd_steer.sv
module wbna_rd_steer #(
  parameter int M_DW = 64,
  parameter int S_DW = 8,
  localparam int LANES = M_DW / S_DW,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] lane_idx,
  input  logic [S_DW-1:0]  narrow,
  output logic [M_DW-1:0]  wide
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wide[g*S_DW +: S_DW] = (en && lane_idx == IDX_W'(g)) ? narrow : '0;
  end

endmodule

// File: rtl/wbna_reject_resp.sv
module wbna_reject_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic rej_req,
  output logic ack_q
);

  // One wait state, then a single-cycle pulse. It toggles if the strobe is held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= rej_req & ~ack_q;
  end

endmodule

// File: rtl/wbna_adapter.sv
module wbna_adapter
  import wbna_pkg::*;
#(
  parameter int M_DW    = 64,
  parameter int S_DW    = 8,
  parameter int S_AW    = 12,
  parameter bit REJ_ERR = 1'b1,
  localparam int LANES = M_DW / S_DW,
  localparam int IDX_W = $clog2(LANES),
  localparam int WA_W  = S_AW - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WA_W-1:0]  m_wadr,
  input  logic [M_DW-1:0]  m_dat_w,
  input  logic [LANES-1:0] m_sel,
  input  logic             m_cyc,
  input  logic             m_stb,
  input  logic             m_we,
  output logic [M_DW-1:0]  m_dat_r,
  output logic             m_ack,
  output logic             m_err,
  output logic [S_AW-1:0]  s_adr,
  output logic [S_DW-1:0]  s_dat_w,
  output logic             s_we,
  output logic             s_stb,
  output logic             s_cyc,
  input  logic [S_DW-1:0]  s_dat_r,
  input  logic             s_ack
);

  logic             one_hot;
  logic [IDX_W-1:0] lane_idx;
  route_e           route;
  logic             fwd;
  logic             rej_req;
  logic             rej_ack;
  logic [M_DW-1:0]  steered;

  wbna_lane_decode #(.LANES(LANES)) u_dec (
    .sel      (m_sel),
    .cyc      (m_cyc),
    .one_hot  (one_hot),
    .lane_idx (lane_idx),
    .route    (route)
  );

  assign fwd     = (route == ROUTE_FWD);
  assign rej_req = (route == ROUTE_REJ) & m_stb;

  wbna_wr_mux #(.M_DW(M_DW), .S_DW(S_DW)) u_wr (
    .wide     (m_dat_w),
    .lane_idx (lane_idx),
    .narrow   (s_dat_w)
  );

  wbna_rd_steer #(.M_DW(M_DW), .S_DW(S_DW)) u_rd (
    .en       (fwd),
    .lane_idx (lane_idx),
    .narrow   (s_dat_r),
    .wide     (steered)
  );

  wbna_reject_resp u_rej (
    .clk     (clk),
    .rst_n   (rst_n),
    .rej_req (rej_req),
    .ack_q   (rej_ack)
  );

  assign s_adr = {m_wadr, lane_idx};
  assign s_we  = m_we;
  assign s_stb = m_stb;
  assign s_cyc = m_cyc & one_hot;

  assign m_ack   = fwd ? s_ack : rej_ack;
  assign m_dat_r = fwd ? steered : (rej_ack ? '1 : '0);

  if (REJ_ERR) begin : g_err
    assign m_err = rej_ack & ~fwd;
  end else begin : g_noerr
    assign m_err = 1'b0;
  end

endmodule

// File: rtl/wbna_adapter_chk.sv
module wbna_adapter_chk #(
  parameter int M_DW = 64,
  parameter int S_DW = 8,
  parameter int S_AW = 12,
  localparam int LANES = M_DW / S_DW,
  localparam int IDX_W = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] m_sel,
  input logic             m_cyc,
  input logic             m_stb,
  input logic             m_ack,
  input logic             m_err,
  input logic [M_DW-1:0]  m_dat_r,
  input logic [S_AW-1:0]  s_adr,
  input logic             s_cyc,
  input logic             s_ack,
  input logic [S_DW-1:0]  s_dat_r
);

  // R1
  lane_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_cyc |-> m_sel[s_adr[IDX_W-1:0]]);

  // R4
  multi_sel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(m_sel) > 1) |-> !s_cyc);

  // R5
  zero_sel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel == '0) |-> !s_cyc);

  // R6
  rej_late_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cyc && m_stb && !$onehot(m_sel) && !m_err) |=> m_err);

  // R6
  rej_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |=> !m_err);

  // R6
  rej_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (m_ack && m_dat_r == '1));

  // R7
  rd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cyc && s_ack) |-> (m_dat_r[s_adr[IDX_W-1:0]*S_DW +: S_DW] == s_dat_r));

  // R8
  fwd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_cyc |-> (m_ack == s_ack && !m_err));

endmodule

bind wbna_adapter wbna_adapter_chk #(.M_DW(M_DW), .S_DW(S_DW), .S_AW(S_AW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_sel   (m_sel),
  .m_cyc   (m_cyc),
  .m_stb   (m_stb),
  .m_ack   (m_ack),
  .m_err   (m_err),
  .m_dat_r (m_dat_r),
  .s_adr   (s_adr),
  .s_cyc   (s_cyc),
  .s_ack   (s_ack),
  .s_dat_r (s_dat_r)
);

// File: tb/wbna_adapter_tb_top.sv
module wbna_adapter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  m_wadr = '0;
  logic [63:0] m_dat_w = '0;
  logic [7:0]  m_sel = '0;
  logic        m_cyc = 1'b0;
  logic        m_stb = 1'b0;
  logic        m_we = 1'b0;
  logic [63:0] m_dat_r;
  logic        m_ack;
  logic        m_err;
  logic [11:0] s_adr;
  logic [7:0]  s_dat_w;
  logic        s_we;
  logic        s_stb;
  logic        s_cyc;
  logic [7:0]  s_dat_r = '0;
  logic        s_ack = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wbna_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .m_wadr(m_wadr), .m_dat_w(m_dat_w), .m_sel(m_sel),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_dat_r(m_dat_r), .m_ack(m_ack),
    .m_err(m_err), .s_adr(s_adr), .s_dat_w(s_dat_w), .s_we(s_we), .s_stb(s_stb),
    .s_cyc(s_cyc), .s_dat_r(s_dat_r), .s_ack(s_ack)
  );

  // Upper byte: lane selects, lower byte: slave read byte.
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    16'h01A5, 16'h025A, 16'h043C, 16'h08C3, 16'h100F, 16'h20F0, 16'h4081, 16'h807E,
    16'h0311, 16'h8122, 16'hFF33, 16'h5044, 16'h0055, 16'hC066, 16'h0077, 16'h1899
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_ack == 1'b0, "R9 ack in reset", 64'(m_ack), 64'd0);
    chk(m_err == 1'b0, "R9 err in reset", 64'(m_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: strobe and write enable pass through with no cycle active
    m_stb = 1'b1; m_we = 1'b1; m_sel = 8'h04;
    #1;
    chk(s_stb == 1'b1 && s_we == 1'b1, "R3 idle pass-through", {s_stb, s_we}, 64'd3);
    chk(s_cyc == 1'b0, "R4 no cycle forwarded when idle", 64'(s_cyc), 64'd0);
    @(negedge clk);
    m_stb = 1'b0; m_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  sel;
      logic [7:0]  rb;
      logic [63:0] wd;
      int          nset;
      int          k;
      sel = VEC[i][15:8];
      rb  = VEC[i][7:0];
      wd  = 64'hF7E6D5C4B3A29180 ^ {8{8'(i)}};
      nset = 0;
      k = 0;
      for (int b = 0; b < 8; b++) begin
        if (sel[b]) begin
          nset++;
          k = b;
        end
      end
      @(negedge clk);
      m_wadr = 9'(i * 7 + 3);
      m_dat_w = wd;
      m_sel = sel;
      m_we = i[0];
      m_cyc = 1'b1;
      m_stb = 1'b1;
      s_dat_r = rb;
      s_ack = 1'b1;
      #1;
      chk(s_stb == 1'b1 && s_we == i[0], "R3 strobe/we", {s_stb, s_we}, {1'b1, i[0]});
      if (nset == 1) begin
        chk(s_cyc == 1'b1, "R4 single lane accepted", 64'(s_cyc), 64'd1);
        chk(s_adr == {m_wadr, 3'(k)}, "R1 slave address", 64'(s_adr), 64'({m_wadr, 3'(k)}));
        chk(s_dat_w == 8'(wd >> (8 * k)), "R2 write lane", 64'(s_dat_w), 64'(8'(wd >> (8 * k))));
        chk(m_ack == 1'b1 && m_err == 1'b0, "R8 ack follows", {m_ack, m_err}, 64'd2);
        chk(m_dat_r == (64'(rb) << (8 * k)), "R7 read lane", m_dat_r, 64'(rb) << (8 * k));
        s_ack = 1'b0;
        #1;
        chk(m_ack == 1'b0, "R8 no ack without slave ack", 64'(m_ack), 64'd0);
      end else begin
        chk(s_cyc == 1'b0, nset == 0 ? "R5 zero select blocked" : "R4 multi select blocked",
            64'(s_cyc), 64'd0);
        chk(m_ack == 1'b0, "R6 no ack in first cycle", 64'(m_ack), 64'd0);
        @(posedge clk);
        #1;
        chk(m_ack == 1'b1 && m_err == 1'b1, "R6 reject ack and err", {m_ack, m_err}, 64'd3);
        chk(m_dat_r == '1, "R6 reject read ones", m_dat_r, '1);
        @(posedge clk);
        #1;
        chk(m_ack == 1'b0 && m_err == 1'b0, "R6 single pulse", {m_ack, m_err}, 64'd0);
      end
      @(negedge clk);
      m_cyc = 1'b0;
      m_stb = 1'b0;
      s_ack = 1'b0;
    end

    // R9: reset clears a pending reject acknowledge
    @(negedge clk);
    m_sel = 8'h00; m_cyc = 1'b1; m_stb = 1'b1;
    @(negedge clk);
    m_cyc = 1'b0; m_stb = 1'b0; rst_n = 1'b0;
    #1;
    chk(m_ack == 1'b0 && m_err == 1'b0, "R9 reset clears reject", {m_ack, m_err}, 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule